// File: doc/BRIEF.md
# MSI Capability Register Block

This block holds the register image of a PCI-style Message Signalled Interrupt capability and updates it from a simple configuration write port. Each write carries a byte offset, a 32-bit data word and an access size of 2 or 4 bytes. The block keeps the message control word, the lower and upper message address, the 16-bit message data and the per-vector mask bits. It presents all of them continuously on its outputs.

Two capability bits in the control word are fixed by a parameter at reset. One says the block can use 64-bit addresses and the other says it supports per-vector masking. Together they decide where the message data, upper address and mask registers sit in the offset space, which of those registers exist, and the size of the structure. From the control word the block decodes how many vectors software has enabled and which vectors count as masked. It also raises one-cycle events for the interrupt routing logic: enable on a rising MSI enable, disable on a falling one, and refresh after every accepted write made while MSI is enabled. A write that matches no register changes nothing and raises a one-cycle error pulse.

Top module: `msi_cap_regs`

## Requirements
- R1: On synchronous active-low reset the control output equals the capability parameter with bit 0 and bits 6:4 cleared. Address, data and mask outputs become zero and all event and error pulses are low.
- R2: Only control bit 0 (MSI enable) and bits 6:4 (multi-message enable) can be written. A 2-byte write at offset 0x2 takes them from data bits 15:0. A 4-byte write at offset 0x0 takes them from data bits 31:16. All other control bits hold their reset value.
- R3: A 4-byte write at offset 0x4 stores the lower address with bits 1:0 forced to zero.
- R4: Without the 64-bit capability (control bit 7 = 0), message data sits at offset 0x8 and the mask register sits at offset 0xC.
- R5: With the 64-bit capability, the upper address sits at 0x8 (4-byte only), message data at 0xC and the mask register at 0x10.
- R6: The mask register exists only when control bit 8 (per-vector masking capable) is set. Otherwise its offset matches nothing and the mask output stays zero.
- R7: Message data accepts a 2-byte write, or a 4-byte write of which only data bits 15:0 are kept.
- R8: The enabled-vector count equals 2 to the power of control bits 6:4 when that field is 5 or less, and equals 0 when it is 6 or 7.
- R9: Masked-vector output bit n is 1 only when control bit 8 is set and mask bit n is set.
- R10: The structure-size output is 0x0A, plus 0x04 with the 64-bit capability, plus 0x0A with per-vector masking.
- R11: One cycle after an accepted write, the refresh pulse is high exactly when MSI enable is 1 after that write.
- R12: One cycle after a write that takes MSI enable from 0 to 1, the enable event pulses for one cycle. A write that takes it from 1 to 0 pulses the disable event instead.
- R13: A write whose offset and size match no present register leaves every register unchanged and pulses the error output one cycle later. Accepted writes do not pulse it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_off | input | OFF_W | Byte offset of the write |
| wr_bytes | input | 3 | Access size in bytes; only 2 and 4 are legal |
| wr_data | input | 32 | Write data; a 2-byte write uses bits 15:0 |
| msg_ctl | output | 16 | Message control word |
| msg_addr_lo | output | 32 | Lower message address |
| msg_addr_hi | output | 32 | Upper message address, zero without 64-bit capability |
| msg_data | output | 16 | Message data |
| mask_bits | output | NUM_VEC | Per-vector mask register |
| vec_count | output | 6 | Number of enabled vectors |
| vec_masked | output | NUM_VEC | Effective mask status per vector |
| cap_size | output | 8 | Structure size in bytes |
| ev_enable | output | 1 | One-cycle pulse on MSI enable rising |
| ev_disable | output | 1 | One-cycle pulse on MSI enable falling |
| ev_refresh | output | 1 | One-cycle pulse asking for a routing update |
| wr_err | output | 1 | One-cycle pulse for a write that matched nothing |

## Verification
Every register is a port, so a corrupted register shows up on the cycle after the write that caused it. A misplaced offset decode shows up at once as the wrong register changing or as a spurious error pulse. A wrong stored enable bit shows up the next time the register is written: the refresh pulse appears or disappears, or an enable or disable event is missing or doubled. A mis-decoded vector-count field shows on the count output in the same cycle the control word changes. The bench drives the same write bus into three capability variants at once, so the offset-dependent decode errors, which depend on the parameter values, show up as diverging outputs between the instances.

// File: rtl/msi_cap_pkg.sv
// Package: shared constants, write-target encoding and the vector-count
// decode for the MSI capability register block.
// Assumes a 16-bit control word and at most 32 vectors.
package msi_cap_pkg;

    localparam int CTL_W    = 16;
    localparam int WORD_W   = 32;
    localparam int DATA_W   = 16;
    localparam int MAX_VEC  = 32;
    localparam int VCNT_W   = $clog2(MAX_VEC) + 1;
    localparam int SIZE_W   = 8;

    // control bit positions (decoded by the routing logic)
    localparam int EN_BIT   = 0;
    localparam int MME_LO   = 4;
    localparam int MME_HI   = 6;
    localparam int A64_BIT  = 7;
    localparam int PVM_BIT  = 8;

    localparam logic [CTL_W-1:0] CTL_WR_MASK = 16'h0071;

    localparam logic [SIZE_W-1:0] SIZE_BASE = 8'h0A;
    localparam logic [SIZE_W-1:0] SIZE_A64  = 8'h04;
    localparam logic [SIZE_W-1:0] SIZE_PVM  = 8'h0A;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTL_HALF,
        TGT_CTL_WORD,
        TGT_ADDR_LO,
        TGT_ADDR_HI,
        TGT_DATA,
        TGT_MASK
    } wr_tgt_e;

    // number of vectors selected by the multi-message enable field
    function automatic logic [VCNT_W-1:0] vec_count_of(input logic [2:0] field);
        if (field > 3'd5) begin
            return '0;
        end
        return VCNT_W'(1) << field;
    endfunction

endpackage

// File: rtl/msi_wr_decode.sv
// Module: msi_wr_decode
// Maps a write (offset, size) onto one capability register. The layout
// follows the two fixed capability bits passed as parameters.
// Assumes one write per cycle; purely combinational.
module msi_wr_decode
    import msi_cap_pkg::*;
#(
    parameter int OFF_W  = 8,
    parameter bit ADDR64 = 1'b1,
    parameter bit PVM    = 1'b1
) (
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [2:0]       wr_bytes,
    output wr_tgt_e          tgt,
    output logic             hit,
    output logic             miss
);

    localparam logic [OFF_W-1:0] OFF_CTL_W  = OFF_W'(0);
    localparam logic [OFF_W-1:0] OFF_CTL_H  = OFF_W'(2);
    localparam logic [OFF_W-1:0] OFF_ALO    = OFF_W'(4);
    localparam logic [OFF_W-1:0] OFF_AHI    = OFF_W'(8);
    localparam logic [OFF_W-1:0] OFF_DATA   = ADDR64 ? OFF_W'(12) : OFF_W'(8);
    localparam logic [OFF_W-1:0] OFF_MASK   = ADDR64 ? OFF_W'(16) : OFF_W'(12);

    // select the register addressed by offset and access size
    always_comb begin
        tgt = TGT_NONE;
        if (wr_bytes == 3'd2) begin
            if (wr_off == OFF_CTL_H) begin
                tgt = TGT_CTL_HALF;
            end else if (wr_off == OFF_DATA) begin
                tgt = TGT_DATA;
            end
        end else if (wr_bytes == 3'd4) begin
            if (wr_off == OFF_CTL_W) begin
                tgt = TGT_CTL_WORD;
            end else if (wr_off == OFF_ALO) begin
                tgt = TGT_ADDR_LO;
            end else if (wr_off == OFF_DATA) begin
                tgt = TGT_DATA;
            end else if (ADDR64 && (wr_off == OFF_AHI)) begin
                tgt = TGT_ADDR_HI;
            end else if (PVM && (wr_off == OFF_MASK)) begin
                tgt = TGT_MASK;
            end
        end
    end

    // split the strobe into accepted and rejected writes
    always_comb begin
        hit  = wr_en && (tgt != TGT_NONE);
        miss = wr_en && (tgt == TGT_NONE);
    end

endmodule

// File: rtl/msi_ctl_reg.sv
// Module: msi_ctl_reg
// Holds the message control word. Only the enable bit and the
// multi-message enable field are writable. Produces the enable, disable and
// refresh events, registered so they line up with the updated word.
// Assumes hit/tgt come from msi_wr_decode in the same cycle.
module msi_ctl_reg
    import msi_cap_pkg::*;
#(
    parameter logic [CTL_W-1:0] CAP_CTL = 16'h0186
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  wr_tgt_e           tgt,
    input  logic [WORD_W-1:0] wr_data,
    output logic [CTL_W-1:0]  msg_ctl,
    output logic              ev_enable,
    output logic              ev_disable,
    output logic              ev_refresh
);

    localparam logic [CTL_W-1:0] CTL_RESET = CAP_CTL & ~CTL_WR_MASK;

    logic [CTL_W-1:0] ctl_src;
    logic             ctl_sel;
    logic [CTL_W-1:0] ctl_nxt;

    // merge the writable bits of the incoming half word into the control word
    always_comb begin
        ctl_src = (tgt == TGT_CTL_WORD) ? wr_data[WORD_W-1:CTL_W] : wr_data[CTL_W-1:0];
        ctl_sel = hit && ((tgt == TGT_CTL_HALF) || (tgt == TGT_CTL_WORD));
        ctl_nxt = ctl_sel ? ((msg_ctl & ~CTL_WR_MASK) | (ctl_src & CTL_WR_MASK)) : msg_ctl;
    end

    // register the control word and derive the routing events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_ctl    <= CTL_RESET;
            ev_enable  <= 1'b0;
            ev_disable <= 1'b0;
            ev_refresh <= 1'b0;
        end else begin
            msg_ctl    <= ctl_nxt;
            ev_enable  <= ctl_nxt[EN_BIT] & ~msg_ctl[EN_BIT];
            ev_disable <= ~ctl_nxt[EN_BIT] & msg_ctl[EN_BIT];
            ev_refresh <= hit & ctl_nxt[EN_BIT];
        end
    end

    // R2
    ctl_ro_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(msg_ctl & ~CTL_WR_MASK));

    // R12
    ev_enable_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_enable |-> (msg_ctl[EN_BIT] && !$past(msg_ctl[EN_BIT])));

    // R12
    ev_disable_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_disable |-> (!msg_ctl[EN_BIT] && $past(msg_ctl[EN_BIT])));

    // R12
    ev_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_enable && ev_disable));

    // R11
    ev_refresh_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_refresh |-> msg_ctl[EN_BIT]);

endmodule

// File: rtl/msi_vec_status.sv
// Module: msi_vec_status
// Decodes the enabled-vector count, the effective per-vector mask status
// and the structure size from the control fields and the mask register.
// Assumes the capability bits are constant after reset.
module msi_vec_status
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mme_field,
    input  logic               cap_a64,
    input  logic               cap_pvm,
    input  logic [NUM_VEC-1:0] mask_bits,
    output logic [VCNT_W-1:0]  vec_count,
    output logic [NUM_VEC-1:0] vec_masked,
    output logic [SIZE_W-1:0]  cap_size
);

    // count of vectors granted by software
    always_comb begin
        vec_count = vec_count_of(mme_field);
    end

    // each vector is masked only if masking is supported and its bit is set
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vmask
        assign vec_masked[v] = cap_pvm & mask_bits[v];
    end

    // size grows with the optional upper address and mask/pending words
    always_comb begin
        cap_size = SIZE_BASE
                 + (cap_a64 ? SIZE_A64 : '0)
                 + (cap_pvm ? SIZE_PVM : '0);
    end

    // R8
    vcnt_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec_count));

    // R8
    vcnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mme_field > 3'd5) |-> (vec_count == '0));

    // R9
    vmask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pvm |-> (vec_masked == '0));

endmodule

// File: rtl/msi_cap_regs.sv
// Module: msi_cap_regs (top)
// MSI capability register image with a configuration write port. The layout
// depends on the 64-bit and per-vector-mask bits of CAP_CTL. Optional
// registers are generated only when their capability is present.
// Assumes at most one write per cycle and synchronous active-low reset.
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter logic [15:0] CAP_CTL = 16'h0186,
    parameter int          OFF_W   = 8,
    parameter int          NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [2:0]         wr_bytes,
    input  logic [31:0]        wr_data,
    output logic [15:0]        msg_ctl,
    output logic [31:0]        msg_addr_lo,
    output logic [31:0]        msg_addr_hi,
    output logic [15:0]        msg_data,
    output logic [NUM_VEC-1:0] mask_bits,
    output logic [5:0]         vec_count,
    output logic [NUM_VEC-1:0] vec_masked,
    output logic [7:0]         cap_size,
    output logic               ev_enable,
    output logic               ev_disable,
    output logic               ev_refresh,
    output logic               wr_err
);

    localparam bit ADDR64 = CAP_CTL[A64_BIT];
    localparam bit PVM    = CAP_CTL[PVM_BIT];

    wr_tgt_e tgt;
    logic    hit;
    logic    miss;

    msi_wr_decode #(
        .OFF_W  (OFF_W),
        .ADDR64 (ADDR64),
        .PVM    (PVM)
    ) u_decode (
        .wr_en    (wr_en),
        .wr_off   (wr_off),
        .wr_bytes (wr_bytes),
        .tgt      (tgt),
        .hit      (hit),
        .miss     (miss)
    );

    msi_ctl_reg #(
        .CAP_CTL (CAP_CTL)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .tgt        (tgt),
        .wr_data    (wr_data),
        .msg_ctl    (msg_ctl),
        .ev_enable  (ev_enable),
        .ev_disable (ev_disable),
        .ev_refresh (ev_refresh)
    );

    // lower address register, low two bits always zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_addr_lo <= '0;
        end else if (hit && (tgt == TGT_ADDR_LO)) begin
            msg_addr_lo <= {wr_data[31:2], 2'b00};
        end
    end

    // message data register, keeps the low half of any write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_data <= '0;
        end else if (hit && (tgt == TGT_DATA)) begin
            msg_data <= wr_data[15:0];
        end
    end

    if (ADDR64) begin : g_addr_hi
        // upper address register, present with 64-bit capability
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                msg_addr_hi <= '0;
            end else if (hit && (tgt == TGT_ADDR_HI)) begin
                msg_addr_hi <= wr_data;
            end
        end
    end else begin : g_no_addr_hi
        assign msg_addr_hi = '0;
    end

    if (PVM) begin : g_mask
        // mask register, present with per-vector masking capability
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_bits <= '0;
            end else if (hit && (tgt == TGT_MASK)) begin
                mask_bits <= wr_data[NUM_VEC-1:0];
            end
        end
    end else begin : g_no_mask
        assign mask_bits = '0;
    end

    // one-cycle error pulse for writes that matched no register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= miss;
        end
    end

    msi_vec_status #(
        .NUM_VEC (NUM_VEC)
    ) u_vec (
        .clk        (clk),
        .rst_n      (rst_n),
        .mme_field  (msg_ctl[MME_HI:MME_LO]),
        .cap_a64    (msg_ctl[A64_BIT]),
        .cap_pvm    (msg_ctl[PVM_BIT]),
        .mask_bits  (mask_bits),
        .vec_count  (vec_count),
        .vec_masked (vec_masked),
        .cap_size   (cap_size)
    );

    // R3
    addr_lo_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_addr_lo[1:0] == 2'b00);

    // R13
    err_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> ($stable(msg_ctl) && $stable(msg_addr_lo) && $stable(msg_addr_hi)
                    && $stable(msg_data) && $stable(mask_bits)));

    // R6
    mask_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_ctl[PVM_BIT] |-> (mask_bits == '0));

endmodule

// File: tb/msi_cap_regs_tb.sv
// Bench: three variants on one write bus. u_dut has 64-bit address and
// masking, u_dut_b has 32-bit address and masking, u_dut_c has 64-bit address
// and no masking. Directed tasks, each checking its own results.
module msi_cap_regs_tb;

    localparam int NI = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_off = '0;
    logic [2:0]  wr_bytes = '0;
    logic [31:0] wr_data = '0;

    logic [15:0] o_ctl   [NI];
    logic [31:0] o_lo    [NI];
    logic [31:0] o_hi    [NI];
    logic [15:0] o_data  [NI];
    logic [31:0] o_mask  [NI];
    logic [5:0]  o_vcnt  [NI];
    logic [31:0] o_vmask [NI];
    logic [7:0]  o_size  [NI];
    logic        o_een   [NI];
    logic        o_edis  [NI];
    logic        o_eref  [NI];
    logic        o_err   [NI];

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    msi_cap_regs #(.CAP_CTL(16'h0186)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
        .wr_bytes(wr_bytes), .wr_data(wr_data),
        .msg_ctl(o_ctl[0]), .msg_addr_lo(o_lo[0]), .msg_addr_hi(o_hi[0]),
        .msg_data(o_data[0]), .mask_bits(o_mask[0]), .vec_count(o_vcnt[0]),
        .vec_masked(o_vmask[0]), .cap_size(o_size[0]), .ev_enable(o_een[0]),
        .ev_disable(o_edis[0]), .ev_refresh(o_eref[0]), .wr_err(o_err[0]));

    msi_cap_regs #(.CAP_CTL(16'h0102)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
        .wr_bytes(wr_bytes), .wr_data(wr_data),
        .msg_ctl(o_ctl[1]), .msg_addr_lo(o_lo[1]), .msg_addr_hi(o_hi[1]),
        .msg_data(o_data[1]), .mask_bits(o_mask[1]), .vec_count(o_vcnt[1]),
        .vec_masked(o_vmask[1]), .cap_size(o_size[1]), .ev_enable(o_een[1]),
        .ev_disable(o_edis[1]), .ev_refresh(o_eref[1]), .wr_err(o_err[1]));

    msi_cap_regs #(.CAP_CTL(16'h0080)) u_dut_c (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
        .wr_bytes(wr_bytes), .wr_data(wr_data),
        .msg_ctl(o_ctl[2]), .msg_addr_lo(o_lo[2]), .msg_addr_hi(o_hi[2]),
        .msg_data(o_data[2]), .mask_bits(o_mask[2]), .vec_count(o_vcnt[2]),
        .vec_masked(o_vmask[2]), .cap_size(o_size[2]), .ev_enable(o_een[2]),
        .ev_disable(o_edis[2]), .ev_refresh(o_eref[2]), .wr_err(o_err[2]));

    typedef enum int {S_CTL, S_LO, S_HI, S_DATA, S_MASK, S_VCNT, S_VMASK,
                      S_SIZE, S_EEN, S_EDIS, S_EREF, S_ERR} sel_e;

    function automatic logic [31:0] pick(sel_e s, int i);
        case (s)
            S_CTL:   return 32'(o_ctl[i]);
            S_LO:    return o_lo[i];
            S_HI:    return o_hi[i];
            S_DATA:  return 32'(o_data[i]);
            S_MASK:  return o_mask[i];
            S_VCNT:  return 32'(o_vcnt[i]);
            S_VMASK: return o_vmask[i];
            S_SIZE:  return 32'(o_size[i]);
            S_EEN:   return 32'(o_een[i]);
            S_EDIS:  return 32'(o_edis[i]);
            S_EREF:  return 32'(o_eref[i]);
            default: return 32'(o_err[i]);
        endcase
    endfunction

    task automatic chk3(string req, sel_e s, logic [31:0] e0, logic [31:0] e1, logic [31:0] e2);
        logic [31:0] exp [NI];
        exp[0] = e0; exp[1] = e1; exp[2] = e2;
        for (int i = 0; i < NI; i++) begin
            n_chk++;
            if (pick(s, i) !== exp[i]) begin
                n_err++;
                $display("FAIL %s %s inst%0d: actual=%h expected=%h",
                         req, s.name(), i, pick(s, i), exp[i]);
            end
        end
    endtask

    // present one write for one cycle; outputs are then sampled at a negedge
    task automatic do_wr(logic [7:0] off, logic [2:0] bytes, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_off = off; wr_bytes = bytes; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk3("R1", S_CTL, 32'h186, 32'h102, 32'h080);
        chk3("R1", S_LO, 0, 0, 0);
        chk3("R1", S_HI, 0, 0, 0);
        chk3("R1", S_DATA, 0, 0, 0);
        chk3("R1", S_MASK, 0, 0, 0);
        chk3("R1", S_EEN, 0, 0, 0);
        chk3("R1", S_EREF, 0, 0, 0);
        chk3("R1", S_ERR, 0, 0, 0);
        chk3("R8", S_VCNT, 1, 1, 1);
        chk3("R10", S_SIZE, 32'h18, 32'h14, 32'h0E);
    endtask

    task automatic t_addr_lo();
        do_wr(8'h04, 3'd4, 32'h1234_5677);
        chk3("R3", S_LO, 32'h1234_5674, 32'h1234_5674, 32'h1234_5674);
        chk3("R11", S_EREF, 0, 0, 0);
        chk3("R13", S_ERR, 0, 0, 0);
    endtask

    task automatic t_layout();
        do_wr(8'h08, 3'd4, 32'hAABB_CCDD);
        chk3("R5", S_HI, 32'hAABB_CCDD, 0, 32'hAABB_CCDD);
        chk3("R4", S_DATA, 0, 32'hCCDD, 0);
        chk3("R13", S_ERR, 0, 0, 0);
        do_wr(8'h0C, 3'd4, 32'h5555_0F0F);
        chk3("R7", S_DATA, 32'h0F0F, 32'hCCDD, 32'h0F0F);
        chk3("R4", S_MASK, 0, 32'h5555_0F0F, 0);
        chk3("R13", S_ERR, 0, 0, 0);
        do_wr(8'h10, 3'd4, 32'h8000_0003);
        chk3("R5", S_MASK, 32'h8000_0003, 32'h5555_0F0F, 0);
        chk3("R6", S_ERR, 0, 1, 1);
        chk3("R9", S_VMASK, 32'h8000_0003, 32'h5555_0F0F, 0);
        do_wr(8'h0C, 3'd2, 32'hFFFF_BEEF);
        chk3("R7", S_DATA, 32'hBEEF, 32'hCCDD, 32'hBEEF);
        chk3("R13", S_ERR, 0, 1, 0);
    endtask

    task automatic t_enable();
        do_wr(8'h02, 3'd2, 32'h0000_FFFF);
        chk3("R2", S_CTL, 32'h1F7, 32'h173, 32'h0F1);
        chk3("R12", S_EEN, 1, 1, 1);
        chk3("R12", S_EDIS, 0, 0, 0);
        chk3("R11", S_EREF, 1, 1, 1);
        chk3("R8", S_VCNT, 0, 0, 0);
        @(negedge clk);
        chk3("R12", S_EEN, 0, 0, 0);
        chk3("R11", S_EREF, 0, 0, 0);
        do_wr(8'h00, 3'd4, 32'h0051_FFFF);
        chk3("R2", S_CTL, 32'h1D7, 32'h153, 32'h0D1);
        chk3("R8", S_VCNT, 32, 32, 32);
        chk3("R12", S_EEN, 0, 0, 0);
        chk3("R11", S_EREF, 1, 1, 1);
        do_wr(8'h0C, 3'd2, 32'h0000_1357);
        chk3("R11", S_EREF, 1, 0, 1);
        chk3("R7", S_DATA, 32'h1357, 32'hCCDD, 32'h1357);
    endtask

    task automatic t_disable();
        do_wr(8'h00, 3'd4, 32'h0020_0000);
        chk3("R2", S_CTL, 32'h1A6, 32'h122, 32'h0A0);
        chk3("R12", S_EDIS, 1, 1, 1);
        chk3("R12", S_EEN, 0, 0, 0);
        chk3("R11", S_EREF, 0, 0, 0);
        chk3("R8", S_VCNT, 4, 4, 4);
        do_wr(8'h02, 3'd2, 32'h0000_0030);
        chk3("R8", S_VCNT, 8, 8, 8);
        chk3("R12", S_EDIS, 0, 0, 0);
        do_wr(8'h02, 3'd2, 32'h0000_0060);
        chk3("R8", S_VCNT, 0, 0, 0);
        chk3("R2", S_CTL, 32'h1E6, 32'h162, 32'h0E0);
    endtask

    task automatic t_bad();
        do_wr(8'h02, 3'd4, 32'hFFFF_FFFF);
        chk3("R13", S_ERR, 1, 1, 1);
        chk3("R13", S_CTL, 32'h1E6, 32'h162, 32'h0E0);
        @(negedge clk);
        chk3("R13", S_ERR, 0, 0, 0);
        do_wr(8'h02, 3'd1, 32'h0000_0001);
        chk3("R13", S_ERR, 1, 1, 1);
        chk3("R13", S_EEN, 0, 0, 0);
        do_wr(8'h00, 3'd2, 32'h0000_0001);
        chk3("R13", S_ERR, 1, 1, 1);
        chk3("R13", S_CTL, 32'h1E6, 32'h162, 32'h0E0);
        do_wr(8'h06, 3'd4, 32'hFFFF_FFFF);
        chk3("R13", S_ERR, 1, 1, 1);
        chk3("R13", S_LO, 32'h1234_5674, 32'h1234_5674, 32'h1234_5674);
        chk3("R13", S_HI, 32'hAABB_CCDD, 0, 32'hAABB_CCDD);
        chk3("R13", S_MASK, 32'h8000_0003, 32'h5555_0F0F, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        t_reset();
        t_addr_lo();
        t_layout();
        t_enable();
        t_disable();
        t_bad();
        t_reset();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule